// File: doc/BRIEF.md
# Fractional-Ratio 16 kHz Tick Generator

This block produces a 16 kHz timing event from a 13 MHz system clock. The ratio between the two is 812.5, which no integer counter can produce. Everything runs on the one system clock. The outputs are a clock-enable pulse, one cycle wide, and a level output. Logic elsewhere on the same clock consumes both, so no new clock domain is created.

Two methods are available, and a select input picks one.

- **Counter mode** uses a dual-modulus counter. Its segments alternate between 812 and 813 cycles. Each period is off by at most one input cycle, and the long-run average is exact.
- **Accumulator mode** uses a phase accumulator. It adds a fixed increment every cycle, and its most significant bit is the output. With the default 21-bit width and an increment of 2581, the mean frequency is Fclk·2581/2^21, about 15.9993 kHz.

The select is sampled only while the synchronous reset is applied. A system switches methods by changing the select and then resetting the block.

Top module: `tick16k_gen`

## Requirements
- R1: In the first cycle after a synchronous reset, `tick` is low. `sq_out` is high in counter mode and low in accumulator mode.
- R2: In counter mode (`mode_sel` = 0 at reset), the number of cycles between successive ticks alternates 812, 813, 812, 813, and so on. The count starts at 812, measured from the first cycle after reset.
- R3: In counter mode, every adjacent 812/813 pair of tick intervals totals exactly 1625 cycles.
- R4: In counter mode, `sq_out` is high during each 812-cycle segment and low during each 813-cycle segment. It changes only in the cycle after a tick.
- R5: `tick` is never high in two consecutive cycles.
- R6: In accumulator mode (`mode_sel` = 1 at reset), the accumulator starts at 0 and adds ACC_INC modulo 2^ACC_W each cycle. `sq_out` is the accumulator MSB, and `tick` marks each 0-to-1 change of that MSB.
  - The first tick appears ceil(2^(ACC_W-1)/ACC_INC) cycles after reset.
  - Later ticks are floor(2^ACC_W/ACC_INC) or one more cycles apart.
- R7: In accumulator mode, exactly ACC_INC ticks appear in the 2^ACC_W cycles that follow reset.
- R8: `mode_sel` is sampled only on clock edges where `rst` is high. Changing it at any other time has no effect on `tick` or `sq_out`.
- R9: A reset that lands in the same cycle as a counter-mode tick discards the pending modulus toggle. The next interval is 812, not 813.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (13 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high; also latches `mode_sel` |
| mode_sel | input | 1 | 0 = dual-modulus counter, 1 = phase accumulator |
| tick | output | 1 | One-cycle pulse at each output period boundary |
| sq_out | output | 1 | Level output: modulus segment flag or accumulator MSB |

## Verification
Two events can fall in the same cycle:

- A counter-mode terminal count and a synchronous reset.
- A change of `mode_sel` and a reset edge.

The bench waits until it sees `tick` high, then raises `rst` in that same cycle. The scoreboard must record that tick as the end of an 812-cycle segment. It must also expect the next interval to be 812 rather than 813, which shows that the reset won over the modulus toggle.

The mode select is changed together with a reset and, separately, in the middle of a run. Only the reset-time value may decide which interval pattern follows.

// File: rtl/tick16k_gen.sv
module tick16k_gen #(
  parameter int DIV_LO  = 812,
  parameter int ACC_W   = 21,
  parameter int ACC_INC = 2581
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_sel,
  output logic tick,
  output logic sq_out
);
  localparam int DIV_HI = DIV_LO + 1;
  localparam int CNT_W  = $clog2(DIV_HI);
  localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(DIV_LO - 1);
  localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(DIV_HI - 1);
  localparam logic [ACC_W-1:0] STEP    = ACC_W'(ACC_INC);

  logic             mode_q;
  logic             seg_hi;
  logic [CNT_W-1:0] cnt;
  logic [ACC_W-1:0] acc;
  logic             msb_d;

  wire cnt_end = (cnt == (seg_hi ? LAST_HI : LAST_LO));
  wire acc_msb = acc[ACC_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= mode_sel;
      cnt    <= '0;
      seg_hi <= 1'b0;
      acc    <= '0;
      msb_d  <= 1'b0;
    end else if (mode_q) begin
      acc    <= acc + STEP;
      msb_d  <= acc_msb;
    end else if (cnt_end) begin
      cnt    <= '0;
      seg_hi <= ~seg_hi;
    end else begin
      cnt    <= cnt + 1'b1;
    end
  end

  assign tick   = mode_q ? (acc_msb & ~msb_d) : cnt_end;
  assign sq_out = mode_q ? acc_msb : ~seg_hi;
endmodule

module tick16k_gen_chk #(
  parameter int DIV_LO = 812
) (
  input logic clk,
  input logic rst,
  input logic mode_q,
  input logic tick,
  input logic sq_out
);
  logic [31:0] gap;

  always_ff @(posedge clk) begin
    if (rst || tick) gap <= '0;
    else             gap <= gap + 1'b1;
  end

  // R1: reset leaves no pending pulse
  a_r1_clear: assert property (@(posedge clk) rst |=> !tick);

  // R5
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R2: counter-mode intervals are 812 or 813 cycles
  a_r2_period: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && tick) |-> (gap == 32'(DIV_LO - 1) || gap == 32'(DIV_LO)));

  // R4
  a_r4_sq_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && !tick) |=> $stable(sq_out));

  // R8
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mode_q));
endmodule

bind tick16k_gen tick16k_gen_chk #(.DIV_LO(DIV_LO)) u_chk (
  .clk(clk), .rst(rst), .mode_q(mode_q), .tick(tick), .sq_out(sq_out)
);

// File: tb/test_tick16k_gen.sv
module test_tick16k_gen;
  localparam int LO  = 812;
  localparam int W   = 16;
  localparam int INC = 2581;
  localparam int WIN = 1 << W;
  localparam int FIRST_ACC = ((1 << (W - 1)) + INC - 1) / INC;
  localparam int GAP_LO = WIN / INC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_sel = 1'b0;
  logic tick, sq_out;

  bit tb_mode = 1'b0;
  bit rst_seen = 1'b1;
  bit acc_done = 1'b0;
  int n_chk = 0;
  int n_fail = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  tick16k_gen #(.DIV_LO(LO), .ACC_W(W), .ACC_INC(INC)) i_tick16k_gen (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .tick(tick), .sq_out(sq_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) rst_seen = rst;

  // monitor / scoreboard
  initial begin
    int idx;
    int last;
    int prev_gap;
    int acc_n;
    bit ptk;
    idx = 0; last = -1; prev_gap = 0; acc_n = 0; ptk = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_seen) begin
        idx = 1; last = -1; prev_gap = 0; acc_n = 0; ptk = 1'b0;
        if (!rst) begin
          chk(tick == 1'b0, "R1 tick after reset", int'(tick), 0);
          chk(sq_out == !tb_mode, "R1 sq_out after reset", int'(sq_out), int'(!tb_mode));
        end
      end else begin
        if (tick === 1'b1) begin
          chk(!ptk, "R5 tick width", 2, 1);
          if (!tb_mode) begin
            int gap;
            int e;
            gap = idx - (last < 0 ? -1 : last);
            if (last < 0) gap = idx + 1;
            if (exp_q.size() == 0) begin
              chk(1'b0, "R2 unexpected tick", gap, 0);
            end else begin
              e = exp_q.pop_front();
              chk(gap == e, "R2/R9 tick interval", gap, e);
              chk(sq_out == (e == LO), "R4 sq_out segment level", int'(sq_out), int'(e == LO));
              if (e == LO + 1)
                chk(prev_gap + gap == 2 * LO + 1, "R3 pair total", prev_gap + gap, 2 * LO + 1);
            end
            prev_gap = gap;
          end else if (idx < WIN) begin
            acc_n++;
            chk(sq_out == 1'b1, "R6 sq_out is MSB at tick", int'(sq_out), 1);
            if (last < 0)
              chk(idx == FIRST_ACC, "R6 first accumulator tick", idx, FIRST_ACC);
            else
              chk((idx - last == GAP_LO) || (idx - last == GAP_LO + 1),
                  "R6 accumulator interval", idx - last, GAP_LO);
          end
          last = idx;
        end
        ptk = (tick === 1'b1);
        if (tb_mode && idx == WIN && !acc_done) begin
          chk(acc_n == INC, "R7 ticks per full accumulator wrap", acc_n, INC);
          acc_done = 1'b1;
        end
        idx++;
      end
    end
  end

  // driver
  initial begin
    repeat (4) @(posedge clk);
    #1;
    for (int k = 0; k < 3; k++) begin
      exp_q.push_back(LO);
      exp_q.push_back(LO + 1);
    end
    rst = 1'b0;
    repeat (2000) @(posedge clk);
    #1 mode_sel = 1'b1;                 // R8: ignored mid-run
    wait (exp_q.size() == 0);

    // R9: reset collides with a terminal count
    exp_q.push_back(LO);
    forever begin
      @(posedge clk);
      #1;
      if (tick) break;
    end
    rst = 1'b1;
    mode_sel = 1'b0;
    exp_q.push_back(LO);
    exp_q.push_back(LO + 1);
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    wait (exp_q.size() == 0);

    // accumulator mode, select changed together with reset
    @(posedge clk);
    #1 rst = 1'b1;
    mode_sel = 1'b1;
    @(posedge clk);
    #1 tb_mode = 1'b1;
    @(posedge clk);
    #1 rst = 1'b0;
    mode_sel = 1'b0;                    // R8: ignored after reset
    wait (acc_done);
    repeat (4) @(posedge clk);
    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end
endmodule